// File: doc/BRIEF.md
# Three-Pass Subranging Conversion Sequencer

This block runs the digital side of a subranging converter that reuses one 7-bit flash quantizer three times per sample. It drives a feedback DAC and a gain-select field to an analog front end and controls the sample/hold. It collects one flash code per pass and merges the three codes into a 17-bit sum. Each pass 2 and pass 3 code is read as a signed remainder around mid-code. Each merge shifts the running estimate left by 5 bits before it adds the next remainder, so adjacent passes overlap by two bits. That overlap lets a later pass correct an earlier one in either direction.

A conversion begins with a start pulse. The DAC goes to mid-scale, the hold command asserts, and the gain is set to unity. After each accepted flash code the block moves the DAC to the estimate so far and raises the gain by 32. Once the third code is taken, the hold is released and the DAC returns to mid-scale right away, so the next acquisition can start. The final sum is then clamped to the 17-bit range, and its upper 16 bits are loaded into the result register. The result also goes out as two bytes on an 8-bit bus.

The flash input is a valid/ready stream. The source holds `flash_code_i` steady with `flash_valid_i` high until a cycle in which `flash_ready_o` is also high, and only that cycle transfers a code. Ready is high only while the sequencer is waiting for a pass code. The byte output has no back-pressure: each byte is qualified by a one-cycle strobe, and the receiver must take it.

Top module: `subrange_seq`

## Requirements
- R1: After reset the block is idle. `busy_o`=0, `hold_o`=0, `flash_ready_o`=0, `byte_stb_o`=0, `gain_sel_o`=2'b00, and `dac_code_o` is mid-scale (2048).
- R2: When the block is idle, a start pulse sets the following on the next cycle: `busy_o`=1, `hold_o`=1, `dac_code_o`=2048, `gain_sel_o`=2'b00 (unity) and `flash_ready_o`=1. A start while `busy_o` is high is ignored and leaves the DAC code and gain unchanged.
- R3: After the pass 1 code c1 is accepted, `dac_code_o` = c1·32 and `gain_sel_o` = 2'b01 (×32).
- R4: After the pass 2 code c2 is accepted, `dac_code_o` = c1·32 + (c2 − 64), clamped to 0..4095, and `gain_sel_o` = 2'b10 (×1024). The value 2'b11 never appears.
- R5: On the cycle after the pass 3 code c3 is accepted: `hold_o`=0, `dac_code_o`=2048, `gain_sel_o`=2'b00 and `flash_ready_o`=0, while `busy_o` is still 1.
- R6: The final sum is S = c1·1024 + (c2 − 64)·32 + (c3 − 64). It is clamped to 0..131071. `result_o` holds bits 16..1 of the clamped value, and `overrange_o` is 1 exactly when clamping changed S.
- R7: One cycle after the pass 3 transfer, `result_o` and `overrange_o` are loaded and `busy_o` falls on that same cycle.
- R8: On the cycle `busy_o` falls, `byte_stb_o` is high with `byte_o` = result bits 15..8. On the next cycle it is high with bits 7..0. On the cycle after that it is low.
- R9: A flash code transfers only when `flash_valid_i` and `flash_ready_o` are both high. A valid while idle has no effect, and `flash_ready_o` is never high without `busy_o` and `hold_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Conversion start pulse |
| flash_valid_i | input | 1 | Flash code valid |
| flash_code_i | input | 7 | Flash quantizer code |
| flash_ready_o | output | 1 | Sequencer waiting for a pass code |
| dac_code_o | output | 12 | Feedback DAC code |
| gain_sel_o | output | 2 | Gain select: 00 ×1, 01 ×32, 10 ×1024 |
| hold_o | output | 1 | Sample/hold command, 1 = hold |
| busy_o | output | 1 | Conversion in progress |
| result_o | output | 16 | Clamped result, upper 16 bits of the sum |
| overrange_o | output | 1 | Last result was clamped |
| byte_o | output | 8 | Serialized result byte |
| byte_stb_o | output | 1 | Byte strobe, one cycle per byte |

## Verification
The bench sweeps every pass 1 code against pass 2 and pass 3 codes at the extremes and around mid-code. This reaches both clamps: a negative sum (c1=0 with low remainders) must read as zero with the flag set, and sums above full scale at c1=127 must read as all ones. A design that rolls over instead of clamping would show a wrapped result, and one that treats remainders as unsigned would be off by 64 or 2048 LSBs at mid-code. Flash valids are delayed by zero to two cycles, sent while idle, and starts are pulsed mid-conversion. A design that takes codes without ready, or restarts when busy, would lose pass alignment. The DAC clamp before pass 3, hold release before the result load, and byte order are all checked against the cycle of the pass 3 transfer.

// File: rtl/subrange_pkg.sv
package subrange_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_P1, ST_P2, ST_P3, ST_FIN} seq_state_t;
  localparam logic [1:0] GAIN_X1  = 2'b00;
  localparam logic [1:0] GAIN_X32 = 2'b01;
  localparam logic [1:0] GAIN_X1K = 2'b10;
endpackage

// File: rtl/subrange_merge.sv
// Shifts a running estimate up by one pass and adds a mid-centred remainder.
module subrange_merge #(
  parameter int CODE_W = 7,
  parameter int SHIFT  = 5,
  parameter int ACC_W  = 19
) (
  input  logic signed [ACC_W-1:0]  acc_i,
  input  logic        [CODE_W-1:0] code_i,
  output logic signed [ACC_W-1:0]  sum_o
);
  localparam logic signed [ACC_W-1:0] MID = ACC_W'(2 ** (CODE_W - 1));
  logic signed [ACC_W-1:0] rem;

  assign rem   = $signed({{(ACC_W-CODE_W){1'b0}}, code_i}) - MID;
  assign sum_o = (acc_i <<< SHIFT) + rem;
endmodule

// File: rtl/subrange_sat.sv
// Clamps a signed value into the unsigned range 0 .. 2^OUT_W-1.
module subrange_sat #(
  parameter int IN_W  = 19,
  parameter int OUT_W = 12
) (
  input  logic signed [IN_W-1:0] val_i,
  output logic        [OUT_W-1:0] sat_o
);
  localparam logic signed [IN_W-1:0] TOP = $signed({{(IN_W-OUT_W){1'b0}}, {OUT_W{1'b1}}});

  always_comb begin
    if (val_i < 0)        sat_o = '0;
    else if (val_i > TOP) sat_o = '1;
    else                  sat_o = val_i[OUT_W-1:0];
  end
endmodule

// File: rtl/subrange_bytes.sv
// Sends a word most significant byte first, one strobed byte per cycle.
module subrange_bytes #(
  parameter int WORD_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic              stb_o
);
  localparam int NBYTES = WORD_W / BYTE_W;
  localparam int CNT_W  = $clog2(NBYTES + 1);

  logic [WORD_W-1:0] sh_q;
  logic [CNT_W-1:0]  left_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q   <= '0;
      left_q <= '0;
      byte_o <= '0;
      stb_o  <= 1'b0;
    end else if (load_i) begin
      byte_o <= word_i[WORD_W-1 -: BYTE_W];
      sh_q   <= word_i << BYTE_W;
      left_q <= CNT_W'(NBYTES - 1);
      stb_o  <= 1'b1;
    end else if (left_q != '0) begin
      byte_o <= sh_q[WORD_W-1 -: BYTE_W];
      sh_q   <= sh_q << BYTE_W;
      left_q <= left_q - 1'b1;
      stb_o  <= 1'b1;
    end else begin
      stb_o  <= 1'b0;
    end
  end
endmodule

// File: rtl/subrange_ctrl.sv
// Pass sequencer: DAC, gain, hold, running estimate and result register.
module subrange_ctrl
  import subrange_pkg::*;
#(
  parameter int CODE_W = 7,
  parameter int SHIFT  = 5,
  parameter int ACC_W  = 19,
  parameter int DAC_W  = 12,
  parameter int RES_W  = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start_i,
  input  logic                    valid_i,
  input  logic [CODE_W-1:0]       code_i,
  input  logic signed [ACC_W-1:0] merged_i,
  input  logic [DAC_W-1:0]        dac_clamped_i,
  input  logic [RES_W-1:0]        final_i,
  input  logic                    clip_i,
  output logic                    ready_o,
  output logic [DAC_W-1:0]        dac_o,
  output logic [1:0]              gain_o,
  output logic                    hold_o,
  output logic                    busy_o,
  output logic signed [ACC_W-1:0] acc_o,
  output logic [RES_W-1:0]        result_o,
  output logic                    ovr_o,
  output logic                    load_o
);
  localparam logic [DAC_W-1:0] DAC_MID = DAC_W'(2 ** (DAC_W - 1));

  seq_state_t state_q;
  logic       take;

  assign ready_o = (state_q == ST_P1) || (state_q == ST_P2) || (state_q == ST_P3);
  assign take    = valid_i && ready_o;
  assign load_o  = (state_q == ST_FIN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      dac_o    <= DAC_MID;
      gain_o   <= GAIN_X1;
      hold_o   <= 1'b0;
      busy_o   <= 1'b0;
      acc_o    <= '0;
      result_o <= '0;
      ovr_o    <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_P1;
          busy_o  <= 1'b1;
          hold_o  <= 1'b1;
          dac_o   <= DAC_MID;
          gain_o  <= GAIN_X1;
        end
        ST_P1: if (take) begin
          acc_o   <= $signed({{(ACC_W-CODE_W){1'b0}}, code_i});
          dac_o   <= {code_i, {SHIFT{1'b0}}};
          gain_o  <= GAIN_X32;
          state_q <= ST_P2;
        end
        ST_P2: if (take) begin
          acc_o   <= merged_i;
          dac_o   <= dac_clamped_i;
          gain_o  <= GAIN_X1K;
          state_q <= ST_P3;
        end
        ST_P3: if (take) begin
          acc_o   <= merged_i;
          hold_o  <= 1'b0;
          dac_o   <= DAC_MID;
          gain_o  <= GAIN_X1;
          state_q <= ST_FIN;
        end
        ST_FIN: begin
          result_o <= final_i;
          ovr_o    <= clip_i;
          busy_o   <= 1'b0;
          state_q  <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/subrange_seq.sv
module subrange_seq #(
  parameter int CODE_W = 7,
  parameter int SHIFT  = 5,
  parameter int BYTE_W = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start_i,
  input  logic                       flash_valid_i,
  input  logic [CODE_W-1:0]          flash_code_i,
  output logic                       flash_ready_o,
  output logic [CODE_W+SHIFT-1:0]    dac_code_o,
  output logic [1:0]                 gain_sel_o,
  output logic                       hold_o,
  output logic                       busy_o,
  output logic [CODE_W+2*SHIFT-2:0]  result_o,
  output logic                       overrange_o,
  output logic [BYTE_W-1:0]          byte_o,
  output logic                       byte_stb_o
);
  localparam int DAC_W = CODE_W + SHIFT;
  localparam int SUM_W = CODE_W + 2 * SHIFT;
  localparam int RES_W = SUM_W - 1;
  localparam int ACC_W = SUM_W + 2;

  logic signed [ACC_W-1:0] acc_q, merged;
  logic [DAC_W-1:0]        dac_clamped;
  logic [SUM_W-1:0]        final_full;
  logic                    clip, load;

  subrange_merge #(.CODE_W(CODE_W), .SHIFT(SHIFT), .ACC_W(ACC_W)) u_merge (
    .acc_i(acc_q), .code_i(flash_code_i), .sum_o(merged)
  );

  subrange_sat #(.IN_W(ACC_W), .OUT_W(DAC_W)) u_dac_sat (
    .val_i(merged), .sat_o(dac_clamped)
  );

  subrange_sat #(.IN_W(ACC_W), .OUT_W(SUM_W)) u_fin_sat (
    .val_i(acc_q), .sat_o(final_full)
  );

  assign clip = ($signed({{(ACC_W-SUM_W){1'b0}}, final_full}) != acc_q);

  subrange_ctrl #(
    .CODE_W(CODE_W), .SHIFT(SHIFT), .ACC_W(ACC_W), .DAC_W(DAC_W), .RES_W(RES_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .valid_i(flash_valid_i), .code_i(flash_code_i),
    .merged_i(merged), .dac_clamped_i(dac_clamped),
    .final_i(final_full[SUM_W-1 -: RES_W]), .clip_i(clip),
    .ready_o(flash_ready_o), .dac_o(dac_code_o), .gain_o(gain_sel_o),
    .hold_o(hold_o), .busy_o(busy_o), .acc_o(acc_q),
    .result_o(result_o), .ovr_o(overrange_o), .load_o(load)
  );

  subrange_bytes #(.WORD_W(RES_W), .BYTE_W(BYTE_W)) u_bytes (
    .clk(clk), .rst_n(rst_n), .load_i(load),
    .word_i(final_full[SUM_W-1 -: RES_W]),
    .byte_o(byte_o), .stb_o(byte_stb_o)
  );
endmodule

// File: rtl/subrange_seq_chk.sv
module subrange_seq_chk #(
  parameter int CODE_W = 7,
  parameter int SHIFT  = 5,
  parameter int BYTE_W = 8
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      start_i,
  input logic                      flash_valid_i,
  input logic [CODE_W-1:0]         flash_code_i,
  input logic                      flash_ready_o,
  input logic [CODE_W+SHIFT-1:0]   dac_code_o,
  input logic [1:0]                gain_sel_o,
  input logic                      hold_o,
  input logic                      busy_o,
  input logic [CODE_W+2*SHIFT-2:0] result_o,
  input logic [BYTE_W-1:0]         byte_o,
  input logic                      byte_stb_o
);
  localparam int DAC_W = CODE_W + SHIFT;
  localparam int RES_W = CODE_W + 2 * SHIFT - 1;
  localparam logic [DAC_W-1:0] MID = DAC_W'(2 ** (DAC_W - 1));

  // R2
  start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && !busy_o |=> busy_o && hold_o && dac_code_o == MID && gain_sel_o == 2'b00 && flash_ready_o);

  // R2
  start_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && busy_o && flash_ready_o && !flash_valid_i |=> busy_o && $stable(gain_sel_o) && $stable(dac_code_o));

  // R3
  pass_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flash_valid_i && flash_ready_o && gain_sel_o == 2'b00
      |=> gain_sel_o == 2'b01 && dac_code_o == {$past(flash_code_i), {SHIFT{1'b0}}});

  // R4
  gain_code_chk: assert property (@(posedge clk) disable iff (!rst_n) gain_sel_o != 2'b11);

  // R5
  hold_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flash_valid_i && flash_ready_o && gain_sel_o == 2'b10
      |=> !hold_o && busy_o && !flash_ready_o && dac_code_o == MID && gain_sel_o == 2'b00);

  // R7
  busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> byte_stb_o && byte_o == result_o[RES_W-1 -: BYTE_W]);

  // R8
  low_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |=> byte_stb_o && byte_o == $past(result_o[BYTE_W-1:0]));

  // R8
  strobe_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_stb_o && $past(byte_stb_o) |=> !byte_stb_o);

  // R9
  ready_scope_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flash_ready_o |-> busy_o && hold_o);
endmodule

bind subrange_seq subrange_seq_chk #(.CODE_W(CODE_W), .SHIFT(SHIFT), .BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .flash_valid_i(flash_valid_i),
  .flash_code_i(flash_code_i), .flash_ready_o(flash_ready_o), .dac_code_o(dac_code_o),
  .gain_sel_o(gain_sel_o), .hold_o(hold_o), .busy_o(busy_o), .result_o(result_o),
  .byte_o(byte_o), .byte_stb_o(byte_stb_o)
);

// File: tb/tb_subrange_seq.sv
module tb_subrange_seq;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        flash_valid_i = 1'b0;
  logic [6:0]  flash_code_i = '0;
  logic        flash_ready_o;
  logic [11:0] dac_code_o;
  logic [1:0]  gain_sel_o;
  logic        hold_o, busy_o, overrange_o, byte_stb_o;
  logic [15:0] result_o;
  logic [7:0]  byte_o;

  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  subrange_seq dut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic convert(input int c1, input int c2, input int c3, input int dly, input bit poke);
    int e2, s, sc, res;
    bit ov;
    e2 = c1 * 32 + c2 - 64;
    if (e2 < 0) e2 = 0;
    if (e2 > 4095) e2 = 4095;
    s  = c1 * 1024 + (c2 - 64) * 32 + (c3 - 64);
    ov = (s < 0) || (s > 131071);
    sc = (s < 0) ? 0 : ((s > 131071) ? 131071 : s);
    res = sc >> 1;

    // R9: a valid while idle does nothing
    @(negedge clk); flash_valid_i = 1'b1; flash_code_i = 7'(c3);
    @(negedge clk); flash_valid_i = 1'b0;
    chk(!flash_ready_o && !busy_o && dac_code_o == 12'd2048, "R9 idle valid", int'(dac_code_o), 2048);

    start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    chk(busy_o && hold_o && flash_ready_o && dac_code_o == 12'd2048 && gain_sel_o == 2'b00,
        "R2 start", int'({busy_o, hold_o, flash_ready_o, gain_sel_o}), 5'b11100);

    for (int k = 0; k < dly; k++) begin
      @(negedge clk);
      chk(flash_ready_o && gain_sel_o == 2'b00, "R9 wait pass1", int'(gain_sel_o), 0);
    end
    flash_valid_i = 1'b1; flash_code_i = 7'(c1);
    @(negedge clk); flash_valid_i = 1'b0;
    chk(dac_code_o == 12'(c1 * 32), "R3 dac", int'(dac_code_o), c1 * 32);
    chk(gain_sel_o == 2'b01, "R3 gain", int'(gain_sel_o), 1);

    if (poke) begin
      start_i = 1'b1;
      @(negedge clk); start_i = 1'b0;
      chk(busy_o && gain_sel_o == 2'b01 && dac_code_o == 12'(c1 * 32), "R2 start ignored",
          int'(dac_code_o), c1 * 32);
    end
    flash_valid_i = 1'b1; flash_code_i = 7'(c2);
    @(negedge clk); flash_valid_i = 1'b0;
    chk(dac_code_o == 12'(e2), "R4 dac", int'(dac_code_o), e2);
    chk(gain_sel_o == 2'b10, "R4 gain", int'(gain_sel_o), 2);

    flash_valid_i = 1'b1; flash_code_i = 7'(c3);
    @(negedge clk); flash_valid_i = 1'b0;
    chk(!hold_o && busy_o && !flash_ready_o && dac_code_o == 12'd2048 && gain_sel_o == 2'b00,
        "R5 release", int'(dac_code_o), 2048);

    @(negedge clk);
    chk(!busy_o, "R7 busy", int'(busy_o), 0);
    chk(result_o == 16'(res), "R6 result", int'(result_o), res);
    chk(overrange_o == ov, "R6 overrange", int'(overrange_o), int'(ov));
    chk(byte_stb_o && byte_o == 8'(res >> 8), "R8 high byte", int'(byte_o), (res >> 8) & 255);
    @(negedge clk);
    chk(byte_stb_o && byte_o == 8'(res), "R8 low byte", int'(byte_o), res & 255);
    @(negedge clk);
    chk(!byte_stb_o, "R8 strobe end", int'(byte_stb_o), 0);
  endtask

  initial begin
    int vals[6] = '{0, 1, 63, 64, 65, 127};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy_o && !hold_o && !flash_ready_o && !byte_stb_o && gain_sel_o == 2'b00,
        "R1 reset flags", int'({busy_o, hold_o, flash_ready_o, byte_stb_o}), 0);
    chk(dac_code_o == 12'd2048, "R1 reset dac", int'(dac_code_o), 2048);
    for (int c1 = 0; c1 < 128; c1++)
      for (int i = 0; i < 6; i++)
        for (int j = 0; j < 6; j++)
          convert(c1, vals[i], vals[j], (c1 + i + j) % 3, i == j);
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nchk++;
      nerr++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule